// File: doc/BRIEF.md
# Load/Store-Multiple Transfer Sequencer

This block turns one block-transfer command into a stream of single-word memory accesses. A command carries a base address, a 16-bit register-select mask, a load/store flag, a direction flag and a timing flag. The sequencer walks the selected registers from the lowest number to the highest. It issues one word address and one register index per accepted memory handshake, and the addresses run back to back so that a page-mode memory can stream them. When the list is finished it raises a one-cycle completion pulse. With that pulse it presents the base address moved past the block, so the caller can write it back.

Register 15 holds both the program counter and the status bits. A load whose mask includes it therefore redirects execution, and the completion pulse marks it as a subroutine return. A restore qualifier on the command indicates that flags and mode are reloaded along with the PC. Without the qualifier, only the PC field is taken.

A typical use is a function frame. The link register and a few working registers are stored with decrement-before on entry. On exit the same registers, with R15 in place of R14, are loaded with increment-after from the written-back base, which saves the frame, returns and restores the stack pointer.

Top module: `mxfer_seq`

## Requirements
- R1: Each set bit of `cmdMask` produces exactly one memory transfer. Transfers present `regIdx` in strictly ascending register order, starting from the lowest set bit.
- R2: With `cmdUp`=1 (increment), the first address is the base when `cmdBefore`=0 (after) and base+4 when `cmdBefore`=1 (before). Each later transfer is at the previous address plus 4.
- R3: With `cmdUp`=0 (decrement) and n set bits, the first address is base−4n+4 when `cmdBefore`=0 and base−4n when `cmdBefore`=1. Addresses then still rise by 4, so the lowest register sits at the lowest address.
- R4: With `done`, `wbBase` equals base+4n for increment or base−4n for decrement. `wbValid` equals the latched `cmdWback` flag.
- R5: While `memValid` is high and `memReady` is low, `memValid`, `memAddr` and `regIdx` hold. A transfer counts only when both are high at a clock edge.
- R6: `done` is high for exactly one cycle, in the cycle after the last accepted transfer. `busy` is high from the cycle after a command is taken until that pulse, and low after reset.
- R7: An all-zero mask makes no memory request. It raises `done` in the cycle after the command, with `wbBase` equal to the base.
- R8: `retTaken` is high with `done` exactly when the command was a load (`cmdLoad`=1) and mask bit 15 was set.
- R9: `retRestore` is high with `done` exactly when `retTaken` is high and `cmdRestore` was set. Otherwise only the PC field is reloaded.
- R10: The two lowest bits of the base are ignored. Every `memAddr` and `wbBase` has bits [1:0] equal to zero.
- R11: `cmdStart` is ignored while `busy` is high. `memWrite` is the inverse of the latched `cmdLoad` during transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Take a command when idle |
| cmdBase | input | 32 | Base address |
| cmdMask | input | 16 | Register-select mask, bit i selects register i |
| cmdLoad | input | 1 | 1 = load from memory, 0 = store |
| cmdUp | input | 1 | 1 = increment, 0 = decrement |
| cmdBefore | input | 1 | 1 = step before each word, 0 = after |
| cmdWback | input | 1 | Request base writeback |
| cmdRestore | input | 1 | Restore flags and mode on a return |
| busy | output | 1 | Command in progress |
| memValid | output | 1 | Transfer request valid |
| memReady | input | 1 | Memory accepts the request |
| memWrite | output | 1 | 1 = store transfer |
| memAddr | output | 32 | Word address of the transfer |
| regIdx | output | 4 | Register index of the transfer |
| done | output | 1 | Completion pulse |
| wbValid | output | 1 | Writeback base valid (with done) |
| wbBase | output | 32 | Updated base value |
| retTaken | output | 1 | PC was loaded: return/redirect |
| retRestore | output | 1 | Return also restores flags and mode |

## Verification
The last accepted handshake and the retirement of the final mask bit fall in the same cycle as the decision to end the sequence. A miscount there shows up as one transfer too many or a late completion pulse. The bench provokes this with rotating ready patterns, so the final handshake arrives both directly after earlier handshakes and after stalls. It expects `done` in exactly the following cycle. The second collision is a new start request arriving while the block is still busy. The bench asserts `cmdStart` with a different base and mask one cycle after every command, and judges the addresses, indices and written-back base against the first command only.

// File: rtl/mxfer_pkg.sv
package mxfer_pkg;

  typedef struct packed {
    logic capture;  // latch a new command
    logic advance;  // retire the current transfer
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

endpackage

// File: rtl/mxfer_lowest_pick.sv
module mxfer_lowest_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mxfer_datapath.sv
module mxfer_datapath
  import mxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = $clog2(NREG + 1),
  localparam int SHIFT = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [NREG-1:0]   cmdMask,
  input  logic              cmdLoad,
  input  logic              cmdUp,
  input  logic              cmdBefore,
  input  logic              cmdWback,
  input  logic              cmdRestore,
  output logic [ADDR_W-1:0] curAddr,
  output logic [IDX_W-1:0]  regIdx,
  output logic              cmdEmpty,
  output logic              lastOne,
  output logic [ADDR_W-1:0] baseNext,
  output logic              isLoad,
  output logic              wbEn,
  output logic              hasPc,
  output logic              sBit
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [NREG-1:0]   remMask;
  logic [CNT_W-1:0]  selCount;
  logic [ADDR_W-1:0] span, alignedBase, startAddr, finalBase;

  always_comb begin
    selCount = '0;
    for (int i = 0; i < NREG; i++) selCount = selCount + CNT_W'(cmdMask[i]);
  end

  always_comb begin
    span        = ADDR_W'(selCount) << SHIFT;
    alignedBase = cmdBase & ~(STEP - ADDR_W'(1));
    unique case ({cmdUp, cmdBefore})
      2'b10:   startAddr = alignedBase;
      2'b11:   startAddr = alignedBase + STEP;
      2'b00:   startAddr = alignedBase - span + STEP;
      default: startAddr = alignedBase - span;
    endcase
    finalBase = cmdUp ? alignedBase + span : alignedBase - span;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remMask  <= '0;
      curAddr  <= '0;
      baseNext <= '0;
      isLoad   <= 1'b0;
      wbEn     <= 1'b0;
      hasPc    <= 1'b0;
      sBit     <= 1'b0;
    end else if (strobe.capture) begin
      remMask  <= cmdMask;
      curAddr  <= startAddr;
      baseNext <= finalBase;
      isLoad   <= cmdLoad;
      wbEn     <= cmdWback;
      hasPc    <= cmdMask[NREG-1];
      sBit     <= cmdRestore;
    end else if (strobe.advance) begin
      remMask <= remMask & (remMask - NREG'(1));
      curAddr <= curAddr + STEP;
    end
  end

  mxfer_lowest_pick #(.N(NREG)) u_pick (.vec(remMask), .idx(regIdx));

  assign cmdEmpty = (cmdMask == '0);
  assign lastOne  = ((remMask & (remMask - NREG'(1))) == '0);

  AST_IDX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !lastOne) |=> (regIdx > $past(regIdx))); // R1

endmodule

// File: rtl/mxfer_ctrl.sv
module mxfer_ctrl
  import mxfer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmdStart,
  input  logic      cmdEmpty,
  input  logic      lastOne,
  input  logic      memReady,
  output dpStrobe_t strobe,
  output logic      memValid,
  output logic      busy,
  output logic      done
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (cmdStart) begin
        strobe.capture = 1'b1;
        nextState      = cmdEmpty ? ST_FIN : ST_MOVE;
      end
      ST_MOVE: if (memReady) begin
        strobe.advance = 1'b1;
        if (lastOne) nextState = ST_FIN;
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign memValid = (state == ST_MOVE);
  assign done     = (state == ST_FIN);
  assign busy     = (state != ST_IDLE);

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && memReady && lastOne) |=> done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_EMPTY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmdStart && cmdEmpty) |=> (done && !memValid)); // R7

endmodule

// File: rtl/mxfer_seq.sv
module mxfer_seq
  import mxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int SHIFT = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [NREG-1:0]   cmdMask,
  input  logic              cmdLoad,
  input  logic              cmdUp,
  input  logic              cmdBefore,
  input  logic              cmdWback,
  input  logic              cmdRestore,
  output logic              busy,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [IDX_W-1:0]  regIdx,
  output logic              done,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbBase,
  output logic              retTaken,
  output logic              retRestore
);
  dpStrobe_t strobe;
  logic cmdEmpty, lastOne, isLoad, wbEn, hasPc, sBit;

  mxfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdEmpty(cmdEmpty),
    .lastOne(lastOne), .memReady(memReady), .strobe(strobe),
    .memValid(memValid), .busy(busy), .done(done)
  );

  mxfer_datapath #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cmdBase(cmdBase),
    .cmdMask(cmdMask), .cmdLoad(cmdLoad), .cmdUp(cmdUp), .cmdBefore(cmdBefore),
    .cmdWback(cmdWback), .cmdRestore(cmdRestore), .curAddr(memAddr),
    .regIdx(regIdx), .cmdEmpty(cmdEmpty), .lastOne(lastOne),
    .baseNext(wbBase), .isLoad(isLoad), .wbEn(wbEn), .hasPc(hasPc), .sBit(sBit)
  );

  assign memWrite   = !isLoad;
  assign wbValid    = done && wbEn;
  assign retTaken   = done && isLoad && hasPc;
  assign retRestore = retTaken && sBit;

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    memValid |-> (memAddr[SHIFT-1:0] == '0)); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(regIdx))); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && memReady) |=> (!memValid || memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES))); // R2

endmodule

// File: tb/mxfer_seq_bench.sv
module mxfer_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cmdStart, cmdLoad, cmdUp, cmdBefore, cmdWback, cmdRestore, memReady;
  logic [31:0] cmdBase;
  logic [15:0] cmdMask;
  logic        busy, memValid, memWrite, done, wbValid, retTaken, retRestore;
  logic [31:0] memAddr, wbBase;
  logic [3:0]  regIdx;

  int checks = 0;
  int errors = 0;

  mxfer_seq u_mxfer_seq (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdBase(cmdBase), .cmdMask(cmdMask),
    .cmdLoad(cmdLoad), .cmdUp(cmdUp), .cmdBefore(cmdBefore), .cmdWback(cmdWback),
    .cmdRestore(cmdRestore), .busy(busy), .memValid(memValid), .memReady(memReady),
    .memWrite(memWrite), .memAddr(memAddr), .regIdx(regIdx), .done(done),
    .wbValid(wbValid), .wbBase(wbBase), .retTaken(retTaken), .retRestore(retRestore)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int lowIdx(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic runCase(input logic [31:0] base, input logic [15:0] mask,
                         input bit ld, input bit up, input bit bef,
                         input bit wb, input bit sb, input logic [15:0] seed);
    logic [31:0] ab, span, expAddr, expWb;
    logic [15:0] rem, pat;
    int n, k;
    bit expectDone, doneSeen, stalled;
    string dirReq;
    ab   = base & ~32'h3;
    n    = $countones(mask);
    span = 32'(n * 4);
    if (up) expAddr = bef ? ab + 32'd4 : ab;          // R2
    else    expAddr = bef ? ab - span : ab - span + 32'd4; // R3
    expWb  = up ? ab + span : ab - span;
    dirReq = (base[1:0] != 2'b00) ? "R10" : (up ? "R2" : "R3");
    rem = mask; pat = seed | 16'h0001; k = 0;
    expectDone = (n == 0); doneSeen = 1'b0; stalled = 1'b0;

    @(negedge clk);
    cmdBase = base; cmdMask = mask; cmdLoad = ld; cmdUp = up; cmdBefore = bef;
    cmdWback = wb; cmdRestore = sb; cmdStart = 1'b1;
    for (int cyc = 1; cyc < 120 && !doneSeen; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        // R11: a second start while busy, with other fields, must be ignored
        cmdBase = base + 32'h100; cmdMask = ~mask; cmdUp = ~up; cmdLoad = ~ld;
      end else cmdStart = 1'b0;
      chk(busy === 1'b1, "R6", "busy during command", 32'(busy), 32'd1);
      if (expectDone) begin
        doneSeen = 1'b1; memReady = 1'b0;
        chk(done === 1'b1, "R6", "done after last transfer", 32'(done), 32'd1);
        chk(memValid === 1'b0, "R7", "no request at completion", 32'(memValid), 32'd0);
        chk(wbBase === expWb, (n == 0) ? "R7" : "R4", "wbBase", wbBase, expWb);
        chk(wbBase[1:0] === 2'b00, "R10", "wbBase aligned", wbBase, expWb);
        chk(wbValid === wb, "R4", "wbValid", 32'(wbValid), 32'(wb));
        chk(retTaken === (ld && mask[15]), "R8", "retTaken", 32'(retTaken), 32'(ld && mask[15]));
        chk(retRestore === (ld && mask[15] && sb), "R9", "retRestore",
            32'(retRestore), 32'(ld && mask[15] && sb));
      end else begin
        chk(done === 1'b0, "R6", "no early done", 32'(done), 32'd0);
        chk(memValid === 1'b1, "R1", "request pending", 32'(memValid), 32'd1);
        chk(memAddr === expAddr, stalled ? "R5" : dirReq, "memAddr", memAddr, expAddr);
        chk(32'(regIdx) === 32'(lowIdx(rem)), (cyc == 2) ? "R11" : "R1", "regIdx",
            32'(regIdx), 32'(lowIdx(rem)));
        chk(memWrite === !ld, "R11", "memWrite", 32'(memWrite), 32'(!ld));
        memReady = pat[0];
        stalled  = !pat[0];
        if (pat[0]) begin
          k++;
          rem = rem & (rem - 16'd1);
          expAddr = expAddr + 32'd4;
          if (k == n) expectDone = 1'b1;
        end
        pat = {pat[0], pat[15:1]};
      end
    end
    cmdStart = 1'b0; memReady = 1'b0;
    if (!doneSeen) chk(1'b0, "R6", "completion timeout", 32'(k), 32'(n));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R6", "done single pulse then idle",
        {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R6", "watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] masks [8];
    masks = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h4700, 16'h8421, 16'h00F0, 16'hC003};
    rst_n = 1'b0; cmdStart = 1'b0; cmdBase = '0; cmdMask = '0; cmdLoad = 1'b0;
    cmdUp = 1'b0; cmdBefore = 1'b0; cmdWback = 1'b0; cmdRestore = 1'b0; memReady = 1'b0;
    repeat (3) @(negedge clk);
    chk(memValid === 1'b0, "R6", "reset memValid", 32'(memValid), 32'd0);
    chk(done === 1'b0, "R6", "reset done", 32'(done), 32'd0);
    chk(busy === 1'b0, "R6", "reset busy", 32'(busy), 32'd0);
    rst_n = 1'b1;

    for (int m = 0; m < 8; m++)
      for (int mode = 0; mode < 4; mode++)
        for (int ld = 0; ld < 2; ld++)
          runCase(32'h0000_2000 + 32'(m * 256), masks[m], ld[0], mode[1], mode[0],
                  ((m + mode) % 2) == 1, (m % 2) == 1, 16'(16'h1357 + m * 97 + mode * 31 + ld * 7));

    // R10: misaligned base, low bits dropped
    runCase(32'h0000_3003, 16'h0006, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h00F1);
    runCase(32'h0000_3002, 16'h0102, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0F0F);
    // R8: frame save (decrement-before store of R8..R10, R14), then return load
    runCase(32'h0000_8000, 16'h4700, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF);
    runCase(32'h0000_7FF0, 16'h8700, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h5555);
    runCase(32'h0000_7FF0, 16'h8700, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule